// File: doc/BRIEF.md
# Half-Band Two-Times Interpolator

This block doubles the sample rate of a 14-bit offset-binary stream before it reaches a high-speed converter. Each accepted input sample produces two output samples on the two following clock cycles. The first is an interpolated value from a symmetric 43-tap half-band FIR. The second comes from the single non-zero tap of the other polyphase branch, the centre coefficient.

The clock runs at the output rate. A source therefore presents at most one sample every second cycle, and the output stream is gap-free when inputs arrive on every other cycle. A static mode bit selects the response. With the bit low, the filter is low-pass and keeps the baseband signal. With the bit high, the filter is high-pass: the centre coefficient is negated, which keeps the first image and suppresses the baseband. Arithmetic is done in two's complement, with fixed integer coefficients, rounding and saturation back to 14 bits.

Top module: `hb_interp2x`

## Requirements
- R1: A synchronous active-low reset clears `out_valid` to 0 and sets `out_data` to midscale code 8192. It also fills every delay-line slot with midscale, so samples that follow the reset are filtered against a history of midscale values.
- R2: Each accepted sample produces exactly two valid outputs, on the first and second cycle after the accepting edge: the interpolated value first, then the centre value. Outside such pairs `out_valid` is 0.
- R3: `in_valid` is accepted on every edge except the edge directly after an accepting edge; a sample offered there is ignored and leaves the output stream unchanged.
- R4: Samples at both ports are offset binary, codes 0 to 16383, with 8192 meaning zero. The filter value v of a code c is c - 8192.
- R5: With h[0] the newest accepted value and h[21] the oldest of 22, the interpolated output is the sum over j=0..10 of c_j*(h[10-j]+h[11+j]). The coefficients c_0..c_10 are 20695, -6607, 3703, -2375, 1597, -1076, 712, -455, 275, -149, 64. The sum is rounded as floor((acc+16384)/32768).
- R6: The centre output is h[10] when `mode_hp` is 0 and -h[10] when `mode_hp` is 1.
- R7: Every output value is clamped to the range -8192..8191, which is codes 0..16383.
- R8: A constant input code reappears unchanged at both output phases once the delay line holds only that value.
- R9: `mode_hp` changes only the centre-phase outputs; the interpolated outputs are identical in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | 14 | Input sample, offset binary |
| mode_hp | input | 1 | 0 selects low-pass, 1 selects high-pass; held static while samples flow |
| out_valid | output | 1 | Output sample present this cycle |
| out_data | output | 14 | Output sample, offset binary |

## Verification
A wrong delay-line entry shows up first on the interpolated phase, weighted by its coefficient. It then persists for 22 input samples, and when it reaches slot 10 it also appears on the centre phase. A wrong phase state either breaks the pairing of `out_valid` or swaps interpolated and centre values; the next accepted sample exposes this within two cycles. Rounding and clamping faults appear only at specific sums, so the bench uses steps between the two extremes, impulses in both modes and long random runs, and compares every output against an integer model.

// File: rtl/hb_pkg.sv
// hb_pkg: shared constants, phase type and coefficient table of the
// half-band interpolator. The table holds one side of the symmetric
// non-zero taps, index 0 next to the centre; one side sums to 2^15 / 2.
package hb_pkg;
    localparam int HALF_TAPS = 11;
    localparam int NUM_TAPS  = 4 * HALF_TAPS - 1;
    localparam int LINE_LEN  = 2 * HALF_TAPS;
    localparam int CTR_IDX   = HALF_TAPS - 1;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FIR  = 2'd1,
        PH_CTR  = 2'd2
    } phase_t;

    // One-sided coefficient j (0 = closest to the centre tap).
    function automatic int side_coef(input int j);
        case (j)
            0:       return 20695;
            1:       return -6607;
            2:       return 3703;
            3:       return -2375;
            4:       return 1597;
            5:       return -1076;
            6:       return 712;
            7:       return -455;
            8:       return 275;
            9:       return -149;
            10:      return 64;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/hb_delay_line.sv
// hb_delay_line: shift register of two's-complement samples.
// Slot 0 holds the newest sample. Assumes the caller shifts once per
// accepted input. Reset fills every slot with zero (midscale).
module hb_delay_line #(
    parameter int W   = 14,
    parameter int LEN = 22
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_en,
    input  logic [W-1:0]          din,
    output logic [LEN-1:0][W-1:0] taps
);
    // Shift a new sample in at slot 0 on every accepted input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps <= '0;
        end else if (shift_en) begin
            taps <= {taps[LEN-2:0], din};
        end
    end
endmodule

// File: rtl/hb_fir_branch.sv
// hb_fir_branch: the interpolating polyphase branch. It pre-adds the
// symmetric sample pairs, multiplies each pair by its one-sided coefficient,
// sums, rounds to nearest (ties upward) and clamps to W bits.
// Assumes two's-complement taps, newest in slot 0. Purely combinational.
module hb_fir_branch #(
    parameter int W      = 14,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 15,
    parameter int HALF   = 11
) (
    input  logic [2*HALF-1:0][W-1:0] taps,
    output logic signed [W-1:0]      y
);
    localparam int PROD_W = W + 1 + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(HALF) + 1;
    localparam logic signed [ACC_W-1:0] SAT_HI = (ACC_W'(1) <<< (W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -(ACC_W'(1) <<< (W - 1));
    localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< (FRAC_W - 1);

    logic signed [PROD_W-1:0] prod [HALF];

    genvar j;
    generate
        for (j = 0; j < HALF; j++) begin : g_pair
            localparam logic signed [COEF_W-1:0] CJ = COEF_W'(hb_pkg::side_coef(j));
            logic signed [W:0] pair_sum;
            // Pre-add the two samples that share coefficient j.
            assign pair_sum = $signed({taps[HALF-1-j][W-1], taps[HALF-1-j]})
                            + $signed({taps[HALF+j][W-1], taps[HALF+j]});
            // Weight the pair by its coefficient.
            assign prod[j] = PROD_W'(pair_sum) * PROD_W'(CJ);
        end
    endgenerate

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] scaled;

    // Accumulate, round and clamp.
    always_comb begin
        acc = '0;
        for (int k = 0; k < HALF; k++) begin
            acc = acc + ACC_W'(prod[k]);
        end
        scaled = (acc + HALF_LSB) >>> FRAC_W;
        if (scaled > SAT_HI) begin
            y = SAT_HI[W-1:0];
        end else if (scaled < SAT_LO) begin
            y = SAT_LO[W-1:0];
        end else begin
            y = scaled[W-1:0];
        end
    end
endmodule

// File: rtl/hb_centre_branch.sv
// hb_centre_branch: the single-tap polyphase branch. It passes the centre
// sample through, or negates it for the high-pass response; the one
// value without a positive counterpart is clamped to the maximum.
module hb_centre_branch #(
    parameter int W = 14
) (
    input  logic [W-1:0]        x,
    input  logic                negate,
    output logic signed [W-1:0] y
);
    localparam logic signed [W:0] SAT_HI = (W+1)'((1 << (W - 1)) - 1);

    logic signed [W:0] ext;
    logic signed [W:0] val;

    // Apply the sign of the centre coefficient and clamp.
    always_comb begin
        ext = $signed({x[W-1], x});
        val = negate ? -ext : ext;
        y   = (val > SAT_HI) ? SAT_HI[W-1:0] : val[W-1:0];
    end
endmodule

// File: rtl/hb_interp2x.sv
// hb_interp2x: half-band 2x interpolator, top level. Accepts an offset-binary
// sample when in_valid is high (except on the edge right after an accept).
// It then emits the interpolated value and the centre value on the next
// two cycles. Assumes mode_hp is static while samples are in flight.
module hb_interp2x #(
    parameter int DATA_W = 14,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              mode_hp,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    import hb_pkg::*;

    localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    phase_t                            phase;
    logic                              accept;
    logic [DATA_W-1:0]                 in_tc;
    logic [LINE_LEN-1:0][DATA_W-1:0]   line_taps;
    logic [DATA_W-1:0]                 centre_tap;
    logic                              centre_due;
    logic signed [DATA_W-1:0]          fir_y;
    logic signed [DATA_W-1:0]          ctr_y;

    // Accept unless the interpolated output of the previous sample is due.
    assign accept     = in_valid && (phase != PH_FIR);
    // Offset binary to two's complement: invert the MSB.
    assign in_tc      = {~in_data[DATA_W-1], in_data[DATA_W-2:0]};
    assign centre_tap = line_taps[CTR_IDX];
    assign centre_due = (phase == PH_CTR);

    hb_delay_line #(.W(DATA_W), .LEN(LINE_LEN)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .din      (in_tc),
        .taps     (line_taps)
    );

    hb_fir_branch #(.W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .HALF(HALF_TAPS)) u_fir (
        .taps (line_taps),
        .y    (fir_y)
    );

    hb_centre_branch #(.W(DATA_W)) u_ctr (
        .x      (centre_tap),
        .negate (mode_hp),
        .y      (ctr_y)
    );

    // Sequence the two output phases and register the output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            out_valid <= 1'b0;
            out_data  <= MID_CODE;
        end else begin
            case (phase)
                PH_FIR: begin
                    out_valid <= 1'b1;
                    out_data  <= {~fir_y[DATA_W-1], fir_y[DATA_W-2:0]};
                end
                PH_CTR: begin
                    out_valid <= 1'b1;
                    out_data  <= {~ctr_y[DATA_W-1], ctr_y[DATA_W-2:0]};
                end
                default: begin
                    out_valid <= 1'b0;
                end
            endcase
            if (accept) begin
                phase <= PH_FIR;
            end else if (phase == PH_FIR) begin
                phase <= PH_CTR;
            end else begin
                phase <= PH_IDLE;
            end
        end
    end
endmodule

// File: rtl/hb_interp2x_chk.sv
// hb_interp2x_chk: protocol and centre-path properties of hb_interp2x,
// bound to every instance of it.
module hb_interp2x_chk #(
    parameter int DATA_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              mode_hp,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              centre_due,
    input logic [DATA_W-1:0] centre_tap
);
    localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    int unsigned live_edges;

    // Count edges since reset was released, to bound $past lookups.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_edges <= 0;
        end else if (live_edges < 8) begin
            live_edges <= live_edges + 1;
        end
    end

    // R1: reset leaves the output idle at midscale.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == MID_CODE));

    // R2: an output pair never stops after its first sample.
    assert_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |=> out_valid);

    // R2: every valid output traces back to an input two or three edges earlier.
    assert_valid_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && live_edges >= 3) |-> ($past(in_valid, 2) || $past(in_valid, 3)));

    // R6: in low-pass mode the centre phase reproduces the middle delay slot.
    assert_centre_lp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(centre_due) && !$past(mode_hp)) |->
            (out_data == {~$past(centre_tap[DATA_W-1]), $past(centre_tap[DATA_W-2:0])}));
endmodule

bind hb_interp2x hb_interp2x_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .mode_hp    (mode_hp),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .centre_due (centre_due),
    .centre_tap (centre_tap)
);

// File: tb/tb_hb_interp2x.sv
// tb_hb_interp2x: integer reference model of the interpolator, compared with
// the design at every falling edge, plus directed checks per requirement.
module tb_hb_interp2x;
    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [13:0] in_data;
    logic        mode_hp;
    logic        out_valid;
    logic [13:0] out_data;

    hb_interp2x dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .mode_hp   (mode_hp),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // Reference state.
    int  hist [22];
    bit  m_fir_due = 0;
    bit  m_ctr_due = 0;
    bit  exp_valid = 0;
    int  exp_data  = 8192;
    bit  compare_on = 0;
    int  last_out = 8192;
    bit  seen_top = 0;
    bit  seen_bottom = 0;
    bit  cap_on = 0;
    int  capq [$];

    // R5 coefficients, nearest the centre first.
    int coefs [11] = '{20695, -6607, 3703, -2375, 1597, -1076, 712, -455, 275, -149, 64};

    function automatic int clamp(input longint v);
        if (v > 8191) return 8191;
        if (v < -8192) return -8192;
        return int'(v);
    endfunction

    function automatic int model_fir();
        longint acc = 0;
        for (int j = 0; j < 11; j++) acc += longint'(coefs[j]) * (hist[10-j] + hist[11+j]);
        return clamp((acc + 16384) >>> 15) + 8192;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle model: output phases first (old history), then accept.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (hist[i]) hist[i] = 0;
            m_fir_due = 0; m_ctr_due = 0; exp_valid = 0; exp_data = 8192;
        end else begin
            bit was_fir;
            was_fir = m_fir_due;
            if (m_fir_due) begin
                exp_valid = 1; exp_data = model_fir(); m_fir_due = 0; m_ctr_due = 1;
            end else if (m_ctr_due) begin
                exp_valid = 1; exp_data = clamp(mode_hp ? -hist[10] : hist[10]) + 8192; m_ctr_due = 0;
            end else begin
                exp_valid = 0;
            end
            if (in_valid && !was_fir) begin
                for (int i = 21; i > 0; i--) hist[i] = hist[i-1];
                hist[0] = int'(in_data) - 8192;
                m_fir_due = 1;
            end
        end
    end

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (compare_on) begin
            check(out_valid == exp_valid, "R2", int'(out_valid), int'(exp_valid));
            if (exp_valid) check(int'(out_data) == exp_data, cur_req, int'(out_data), exp_data);
        end
        if (out_valid) begin
            last_out = int'(out_data);
            if (out_data == 14'd16383) seen_top = 1;
            if (out_data == 14'd0) seen_bottom = 1;
            if (cap_on) capq.push_back(int'(out_data));
        end
    end

    task automatic send(input int code);
        @(negedge clk); in_valid = 1; in_data = 14'(code);
        @(negedge clk); in_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; in_valid = 0;
        idle(2);
        rst_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lpq [$];
        int diff_ctr;
        rst_n = 0; in_valid = 0; in_data = 14'd8192; mode_hp = 0;
        idle(3);
        // R1: reset state at the ports.
        check(out_valid == 0, "R1", int'(out_valid), 0);
        check(out_data == 14'd8192, "R1", int'(out_data), 8192);
        compare_on = 1;
        rst_n = 1;

        // R8: constant input returns unchanged.
        cur_req = "R8";
        for (int i = 0; i < 30; i++) send(9192);
        idle(4);
        check(last_out == 9192, "R8", last_out, 9192);

        // R1 / R9: impulse in both modes from a fresh reset.
        cur_req = "R1";
        do_reset();
        cur_req = "R9"; cap_on = 1; capq.delete();
        send(12345);
        for (int i = 0; i < 24; i++) send(8192);
        idle(4); cap_on = 0;
        lpq = capq;
        do_reset();
        mode_hp = 1; cap_on = 1; capq.delete();
        send(12345);
        for (int i = 0; i < 24; i++) send(8192);
        idle(4); cap_on = 0;
        check(lpq.size() == capq.size(), "R2", capq.size(), lpq.size());
        diff_ctr = 0;
        for (int i = 0; i < lpq.size() && i < capq.size(); i++) begin
            if (i % 2 == 0) check(lpq[i] == capq[i], "R9", capq[i], lpq[i]);
            else if (lpq[i] != capq[i]) diff_ctr++;
        end
        // R6: the impulse passes the centre once, with opposite sign in each mode.
        check(diff_ctr == 1, "R6", diff_ctr, 1);

        // R7: full-scale steps overshoot and must clamp.
        cur_req = "R7"; mode_hp = 0; seen_top = 0; seen_bottom = 0;
        for (int i = 0; i < 24; i++) send(0);
        for (int i = 0; i < 24; i++) send(16383);
        for (int i = 0; i < 24; i++) send(0);
        idle(4);
        check(seen_top, "R7", int'(seen_top), 1);
        check(seen_bottom, "R7", int'(seen_bottom), 1);
        mode_hp = 1; seen_top = 0;
        for (int i = 0; i < 24; i++) send(0);
        idle(4);
        check(seen_top, "R7", int'(seen_top), 1);

        // R3: a second cycle of in_valid right after an accept is ignored.
        cur_req = "R3"; mode_hp = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); in_valid = 1; in_data = 14'(9000 + 300 * i);
            @(negedge clk); in_data = 14'(2000);
            @(negedge clk); in_valid = 0;
            idle(i % 3);
        end
        for (int i = 0; i < 24; i++) send(8192 + 1000);
        idle(4);
        check(last_out == 9192, "R3", last_out, 9192);

        // R4 / R5 / R6: random streams with gaps, both modes.
        for (int m = 0; m < 2; m++) begin
            mode_hp = m[0];
            cur_req = (m == 0) ? "R5" : "R6";
            for (int i = 0; i < 300; i++) begin
                send(int'($urandom_range(0, 16383)));
                if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
            end
            idle(4);
        end
        cur_req = "R4";
        for (int i = 0; i < 40; i++) send((i % 2 == 0) ? 0 : 16383);
        idle(4);

        // R1: reset in the middle of a stream.
        cur_req = "R1";
        @(negedge clk); in_valid = 1; in_data = 14'd15000;
        @(negedge clk); in_valid = 0; rst_n = 0;
        idle(2);
        check(out_valid == 0, "R1", int'(out_valid), 0);
        check(out_data == 14'd8192, "R1", int'(out_data), 8192);
        rst_n = 1;
        for (int i = 0; i < 5; i++) send(4000);
        idle(4);

        compare_on = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule